// File: doc/BRIEF.md
# Coded Audio Frame Sync Detector

The detector watches a serial stream of coded audio bits, one bit per cycle in which the bit strobe is high, and finds where each audio frame begins. It offers four ways of finding a candidate frame start, picked by a 2-bit mode input. The first uses an external pulse that marks each frame directly. The second looks for a 14-bit sync word, accepted only on byte boundaries counted from an external alignment pulse. The third looks for a 15-bit sync word at any bit position. The fourth alternates between two 15-bit sync words, and a timeout switches between them.

A candidate is not trusted at once. The block confirms it by finding the same sync word again exactly one frame length later. The number of confirmations depends on whether the stream carries CRC protection and whether it uses a free-format bit rate. Until lock, the mute request stays high. Once locked, every confirmed frame produces a one-cycle start strobe. With the strobe comes the distance, in stream bits, from the frame's first bit back from the bit that confirmed it. The frame length, the CRC flag and the free-format flag come from neighbouring header logic.

The bit stream has a valid strobe but no ready signal. The detector takes one bit in every cycle where the strobe is high and can never apply back-pressure. Idle cycles simply pause the stream. Sync words are written oldest bit first, with X standing for a bit that is not compared.

Top module: `frame_sync_detector`

## Requirements
- R1: After reset, locked is 0, mute is 1 and frame_start is 0.
- R2: In sync_mode 2'b11, a rising edge of sync_in marks a frame start at the bit taken in the same cycle. If the edge comes while bit_valid is low, the mark goes to the next valid bit. The reported lag is 0.
- R3: In sync_mode 2'b10, the word 111111111111X1 is a candidate only if its first bit has byte phase 0. Byte phase counts valid bits modulo 8 from the last marked bit (as in R2), or from the first bit after reset. The reported lag is 13.
- R4: In sync_mode 2'b01, the word 111111111111X10 is a candidate at any bit position, and sync_in has no effect. The reported lag is 14.
- R5: In sync_mode 2'b00, the search starts with word 111111111111X10 (lag 14). On each TIMEOUT_TICKS-th tick pulse while searching, it switches to the other word, 0111111111111X1. For that word the frame start is its first 1 (lag 13).
- R6: The number of confirmations needed after a candidate is 1 with crc_on=0 and free_fmt=0, 2 with crc_on=0 and free_fmt=1, 0 with crc_on=1 and free_fmt=0, and 1 with crc_on=1 and free_fmt=1. With 0, the block locks on the candidate itself.
- R7: A confirmation succeeds when the same sync word completes exactly frame_len valid bits after the previous start. If it is absent at that bit, the search restarts.
- R8: mute is the inverse of locked. While locked, a missing sync word at the expected bit drops lock.
- R9: Each confirmed frame raises frame_start for one cycle, in the cycle after the confirming bit, with its lag on start_lag. This holds both for the confirmation that achieves lock and for every later one while locked.
- R10: Cycles with bit_valid low shift, count and match nothing.
- R11: A change of sync_mode drops lock and restarts the search on the next clock.
- R12: A 15-bit word is only accepted after 14 valid bits have preceded its last bit since reset. A 14-bit word needs 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Stream strobe: bit_data is a stream bit this cycle |
| bit_data | input | 1 | Coded stream bit |
| sync_in | input | 1 | External byte/frame alignment pulse (rising edge used) |
| sync_mode | input | 2 | Search strategy select (see R2 to R5) |
| crc_on | input | 1 | Stream carries CRC protection |
| free_fmt | input | 1 | Stream uses a free-format bit rate |
| frame_len | input | FLW | Frame length in valid bits |
| tick | input | 1 | Sample-clock enable used for the search timeout |
| frame_start | output | 1 | One-cycle strobe per confirmed frame |
| start_lag | output | LAGW | Bits from the frame's first bit to the confirming bit |
| locked | output | 1 | Frame lock held |
| mute | output | 1 | Mute request to the audio outputs |

## Verification
The bench sweeps all four search modes against all four CRC/free-format combinations and predicts the exact bit index of the first start strobe. A wrong confirmation count would shift that index by whole frames, and a wrong lag would shift it by a few bits. Separate runs cover several error cases: a sync word that is one bit late, which must cost a full restart rather than a lock; a word that is byte-misaligned; a frame that is missing after lock; and the alternate word at the very start of the stream, which a design that trusts its reset-filled history would accept. A timeout test pulses the tick one short of the limit and then once more, to catch an off-by-one switch. Idle cycles are scattered through every stream, and the external pulse is sometimes raised during an idle cycle.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } fsd_state_e;

  localparam logic [1:0] MODE_ALT   = 2'b00;
  localparam logic [1:0] MODE_FREE  = 2'b01;
  localparam logic [1:0] MODE_BYTE  = 2'b10;
  localparam logic [1:0] MODE_PULSE = 2'b11;

  // confirmations still needed after a candidate
  function automatic logic [1:0] verify_frames(input logic crc, input logic free);
    if (crc) return free ? 2'd1 : 2'd0;
    else     return free ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/fsd_pattern_match.sv
module fsd_pattern_match
  import fsd_pkg::*;
#(
  parameter int ONES = 12,
  localparam int W    = ONES + 3,
  localparam int LAGW = $clog2(W),
  localparam int FW   = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic            bit_data,
  input  logic            sync_in,
  input  logic [1:0]      mode,
  input  logic            use_alt,
  output logic            hit,
  output logic [LAGW-1:0] lag
);

  localparam int LAG_A = ONES + 2;
  localparam int LAG_B = ONES + 1;
  localparam int LAG_C = ONES + 1;
  localparam logic [2:0] PH_C = 3'(LAG_C % 8);

  logic [W-2:0] hist_q;
  logic [W-1:0] win;
  logic [FW-1:0] fill_q;
  logic [2:0]   phase_q, cur_ph;
  logic         sync_d, pend_q, edge_now, mark;
  logic         pat_a, pat_b, pat_c;

  assign win      = {hist_q, bit_data};
  assign edge_now = sync_in & ~sync_d;
  assign mark     = bit_valid & (edge_now | pend_q);
  assign cur_ph   = mark ? 3'd0 : phase_q;

  assign pat_a = (&win[W-1:3]) & win[1] & ~win[0] & (fill_q >= FW'(W-1));
  assign pat_b = ~win[W-1] & (&win[W-2:2]) & win[0] & (fill_q >= FW'(W-1));
  assign pat_c = (&win[W-2:2]) & win[0] & (fill_q >= FW'(W-2)) & (cur_ph == PH_C);

  always_comb begin
    hit = 1'b0;
    lag = '0;
    unique case (mode)
      MODE_PULSE: begin hit = mark;              lag = '0;            end
      MODE_BYTE:  begin hit = bit_valid & pat_c; lag = LAGW'(LAG_C);  end
      MODE_FREE:  begin hit = bit_valid & pat_a; lag = LAGW'(LAG_A);  end
      default: begin
        if (use_alt) begin hit = bit_valid & pat_b; lag = LAGW'(LAG_B); end
        else         begin hit = bit_valid & pat_a; lag = LAGW'(LAG_A); end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      fill_q  <= '0;
      phase_q <= '0;
      sync_d  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync_d <= sync_in;
      if (bit_valid) begin
        hist_q  <= win[W-2:0];
        phase_q <= cur_ph + 3'd1;
        pend_q  <= 1'b0;
        if (fill_q != FW'(W-1)) fill_q <= fill_q + FW'(1);
      end else if (edge_now) begin
        pend_q <= 1'b1;
      end
    end
  end

  // R10: idle cycles leave the search history untouched
  a_r10_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(hist_q) && $stable(fill_q) && $stable(phase_q)));

  // R12: a word match never fires before the history holds enough bits
  a_r12_fill_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode != MODE_PULSE) |-> fill_q >= FW'(W-2));

endmodule

// File: rtl/fsd_hunt_timer.sv
module fsd_hunt_timer #(
  parameter int TIMEOUT_TICKS = 3500,
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hunting,
  input  logic alt_mode,
  output logic use_alt
);

  localparam logic [TW-1:0] LOAD = TW'(TIMEOUT_TICKS - 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= LOAD;
      use_alt <= 1'b0;
    end else if (!alt_mode) begin
      left_q  <= LOAD;
      use_alt <= 1'b0;
    end else if (!hunting) begin
      left_q <= LOAD;
    end else if (tick) begin
      if (left_q == '0) begin
        left_q  <= LOAD;
        use_alt <= ~use_alt;
      end else begin
        left_q <= left_q - TW'(1);
      end
    end
  end

  // R5: the word choice only flips on a tick while searching
  a_r5_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alt_mode) && use_alt != $past(use_alt)) |-> $past(tick && hunting));

endmodule

// File: rtl/fsd_lock_fsm.sv
module fsd_lock_fsm
  import fsd_pkg::*;
#(
  parameter int FLW  = 16,
  parameter int LAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic            hit,
  input  logic [LAGW-1:0] lag,
  input  logic            crc_on,
  input  logic            free_fmt,
  input  logic [FLW-1:0]  frame_len,
  input  logic            mode_flip,
  output fsd_state_e      state,
  output logic            frame_start,
  output logic [LAGW-1:0] start_lag
);

  localparam int CW = FLW + 1;

  fsd_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, exp_idx, restart;
  logic [1:0]    vneed, vleft_q, vleft_n;
  logic          fire;

  assign vneed   = verify_frames(crc_on, free_fmt);
  assign exp_idx = CW'(frame_len) + CW'(lag);
  assign restart = CW'(lag) + CW'(1);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    vleft_n = vleft_q;
    fire    = 1'b0;
    if (mode_flip) begin
      st_n = ST_HUNT;
    end else if (bit_valid) begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit) begin
            cnt_n = restart;
            if (vneed == 2'd0) begin
              st_n = ST_LOCK;
              fire = 1'b1;
            end else begin
              st_n    = ST_CHECK;
              vleft_n = vneed;
            end
          end
        end
        default: begin
          if (cnt_q >= exp_idx) begin
            if (hit && cnt_q == exp_idx) begin
              cnt_n = restart;
              if (st_q == ST_LOCK) begin
                fire = 1'b1;
              end else if (vleft_q == 2'd1) begin
                st_n = ST_LOCK;
                fire = 1'b1;
              end else begin
                vleft_n = vleft_q - 2'd1;
              end
            end else begin
              st_n = ST_HUNT;
            end
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_HUNT;
      cnt_q       <= '0;
      vleft_q     <= '0;
      frame_start <= 1'b0;
      start_lag   <= '0;
    end else begin
      st_q        <= st_n;
      cnt_q       <= cnt_n;
      vleft_q     <= vleft_n;
      frame_start <= fire;
      if (fire) start_lag <= lag;
    end
  end

  assign state = st_q;

  // R6: lock straight from search only when no confirmation is required
  a_r6_direct_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && $past(st_q) == ST_HUNT) |-> $past(vneed) == 2'd0);

  // R9: a start strobe always follows a consumed bit and comes with lock
  a_r9_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(bit_valid) && st_q == ST_LOCK));

endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
  import fsd_pkg::*;
#(
  parameter int FLW           = 16,
  parameter int ONES          = 12,
  parameter int TIMEOUT_TICKS = 3500,
  localparam int LAGW         = $clog2(ONES + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic            bit_data,
  input  logic            sync_in,
  input  logic [1:0]      sync_mode,
  input  logic            crc_on,
  input  logic            free_fmt,
  input  logic [FLW-1:0]  frame_len,
  input  logic            tick,
  output logic            frame_start,
  output logic [LAGW-1:0] start_lag,
  output logic            locked,
  output logic            mute
);

  logic            hit, use_alt, mode_flip;
  logic [LAGW-1:0] lag;
  logic [1:0]      mode_q;
  fsd_state_e      state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BYTE;
    else        mode_q <= sync_mode;
  end

  assign mode_flip = (sync_mode != mode_q);

  fsd_pattern_match #(.ONES(ONES)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .sync_in  (sync_in),
    .mode     (sync_mode),
    .use_alt  (use_alt),
    .hit      (hit),
    .lag      (lag)
  );

  fsd_hunt_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .hunting (state == ST_HUNT),
    .alt_mode(sync_mode == MODE_ALT),
    .use_alt (use_alt)
  );

  fsd_lock_fsm #(.FLW(FLW), .LAGW(LAGW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .hit        (hit),
    .lag        (lag),
    .crc_on     (crc_on),
    .free_fmt   (free_fmt),
    .frame_len  (frame_len),
    .mode_flip  (mode_flip),
    .state      (state),
    .frame_start(frame_start),
    .start_lag  (start_lag)
  );

  assign locked = (state == ST_LOCK);
  assign mute   = ~locked;

  // R11: a new search mode always costs the lock
  a_r11_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode != $past(sync_mode)) |=> !locked);

endmodule

// File: tb/frame_sync_detector_tb.sv
`timescale 1ns/1ps
module frame_sync_detector_tb;

  localparam int FLW  = 16;
  localparam int LAGW = 4;
  localparam int FL   = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_valid, bit_data, sync_in, crc_on, free_fmt, tick;
  logic [1:0] sync_mode;
  logic [FLW-1:0] frame_len;
  logic frame_start, locked, mute;
  logic [LAGW-1:0] start_lag;

  frame_sync_detector #(.FLW(FLW), .ONES(12), .TIMEOUT_TICKS(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .sync_in(sync_in), .sync_mode(sync_mode), .crc_on(crc_on), .free_fmt(free_fmt),
    .frame_len(frame_len), .tick(tick), .frame_start(frame_start),
    .start_lag(start_lag), .locked(locked), .mute(mute)
  );

  int n_chk = 0, n_err = 0;
  int bidx, first_fs, n_fs, lag_seen;
  logic prev_mute, pre_mute;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic b, input logic s, input logic t);
    @(negedge clk);
    bit_valid = v; bit_data = b; sync_in = s; tick = t;
    @(posedge clk);
    #1;
    if (frame_start) begin
      if (first_fs < 0) begin first_fs = bidx; pre_mute = prev_mute; end
      n_fs++;
      lag_seen = int'(start_lag);
    end
    prev_mute = mute;
    if (v) bidx++;
  endtask

  // R10: idle cycles are slipped in before every 7th bit
  task automatic send_bit(input logic b, input logic s, input logic pre_sync);
    if (bidx % 7 == 3) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    if (pre_sync) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, b, s, 1'b0);
  endtask

  // kind 0: zeros, 1: 15-bit word ending 10, 2: word for the alternate search
  function automatic logic wbit(input int kind, input int i);
    if (kind == 1) return (i < 12) || (i == 13);
    if (kind == 2) return (i < 12) || (i == 13) || (i == 14);
    return 1'b0;
  endfunction

  // smode 0: sync low, 1: pulse on first bit, 2: edge in idle before it, 3: stray pulse
  task automatic send_frame(input int kind, input int len, input int smode);
    for (int i = 0; i < len; i++)
      send_bit(wbit(kind, i),
               (smode == 1 || smode == 2) ? (i == 0) : (smode == 3 && i == 5),
               smode == 2 && i == 0);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic reset_dut(input logic [1:0] m, input logic c, input logic f);
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 0; bit_data = 0; sync_in = 0; tick = 0;
    sync_mode = m; crc_on = c; free_fmt = f; frame_len = FLW'(FL);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    bidx = 0; first_fs = -1; n_fs = 0; lag_seen = -1; prev_mute = 1'b1; pre_mute = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_valid = 0; bit_data = 0; sync_in = 0; tick = 0;
    sync_mode = 2'b10; crc_on = 0; free_fmt = 0; frame_len = FLW'(FL);
    #1;
    chk("R1 locked during reset", int'(locked), 0);
    chk("R1 mute during reset", int'(mute), 1);
    reset_dut(2'b10, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 mute after reset", int'(mute), 1);
    chk("R1 frame_start after reset", int'(frame_start), 0);

    // sweep: every mode against every CRC / free-format combination
    for (int m = 0; m < 4; m++) begin
      for (int cf = 0; cf < 4; cf++) begin
        automatic logic c = cf[0];
        automatic logic f = cf[1];
        automatic int v = c ? (f ? 1 : 0) : (f ? 2 : 1);
        automatic int k = (m == 3) ? 0 : (m == 2) ? 13 : 14;
        automatic string mt = (m == 3) ? "R2" : (m == 2) ? "R3" : (m == 1) ? "R4" : "R5";
        reset_dut(2'(m), c, f);
        zeros(8);
        for (int fr = 0; fr < 5; fr++)
          send_frame((m == 3) ? 0 : 1, FL,
                     (m == 3) ? ((fr % 2 == 1) ? 2 : 1) : (m == 2) ? 1 : (m == 1) ? 3 : 0);
        chk($sformatf("R6 R10 first strobe bit mode%0d crc%0d free%0d", m, c, f),
            first_fs, 8 + v * FL + k);
        chk($sformatf("R7 R9 strobe count mode%0d crc%0d free%0d", m, c, f), n_fs, 5 - v);
        chk($sformatf("%s R9 start_lag crc%0d free%0d", mt, c, f), lag_seen, k);
        chk($sformatf("R8 mute before lock mode%0d crc%0d free%0d", m, c, f), int'(pre_mute), 1);
        chk($sformatf("R8 locked at end mode%0d crc%0d free%0d", m, c, f), int'(locked), 1);
        chk($sformatf("R8 mute at end mode%0d crc%0d free%0d", m, c, f), int'(mute), 0);
      end
    end

    // byte-misaligned word, no alignment pulse
    reset_dut(2'b10, 1'b1, 1'b0);
    zeros(3);
    for (int fr = 0; fr < 3; fr++) send_frame(1, FL, 0);
    chk("R3 misaligned word rejected", n_fs, 0);
    chk("R3 misaligned stays muted", int'(mute), 1);

    // alignment taken from reset
    reset_dut(2'b10, 1'b1, 1'b0);
    zeros(8);
    send_frame(1, FL, 0);
    send_frame(1, FL, 0);
    chk("R3 reset alignment first strobe", first_fs, 8 + 13);
    chk("R3 reset alignment count", n_fs, 2);

    // one-bit-late confirmation must restart the search
    reset_dut(2'b01, 1'b0, 1'b0);
    zeros(4);
    send_frame(1, FL + 1, 0);
    for (int fr = 0; fr < 3; fr++) send_frame(1, FL, 0);
    chk("R7 late word restart first strobe", first_fs, 4 + (FL + 1) + FL + 14);
    chk("R7 late word restart count", n_fs, 2);
    chk("R7 locked after restart", int'(locked), 1);

    // missing frame after lock
    send_frame(0, FL, 0);
    chk("R8 lock lost on missing word", int'(locked), 0);
    chk("R8 mute back on", int'(mute), 1);
    chk("R8 no strobe for missing word", n_fs, 2);

    // alternate-word search timeout
    reset_dut(2'b00, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
    zeros(4);
    send_frame(2, FL, 0);
    chk("R5 no switch before timeout", n_fs, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(2, FL, 0);
    send_frame(2, FL, 0);
    chk("R5 first strobe after timeout", first_fs, 4 + FL + 13);
    chk("R5 R9 alternate word lag", lag_seen, 13);
    chk("R5 strobe count", n_fs, 2);

    // mode change drops lock
    @(negedge clk);
    sync_mode = 2'b01;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 locked after mode change", int'(locked), 0);
    chk("R11 mute after mode change", int'(mute), 1);

    // alternate word at the very start lacks its leading bit
    reset_dut(2'b00, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(2, FL, 0);
    send_frame(2, FL, 0);
    chk("R12 first strobe skips unfilled word", first_fs, FL + 13);
    chk("R12 strobe count", n_fs, 1);

    finish_run();
  end

endmodule